// File: doc/BRIEF.md
# Wishbone Sliced Register Port

This block is a Wishbone classic slave that places one read/write register at a single bus address. A write from the host is captured into an internal holding register. That register is split into equal bit slices, and each slice is driven onto its own lane of the slice output port for the user logic. A read does not return the stored value. It returns whatever the user logic presents on a separate live-data input at the moment the access is served.

The acknowledge comes from inside the block and is registered. A valid strobe to the register address is answered one clock later with a single-cycle `ack_o`, so the user logic can never stall the bus. The word width, slice width, address width and register address are parameters. The slice count is derived from the word and slice widths and checked when the design is elaborated.

Top module: `wbsr_port`

## Requirements
- R1: While `rst_i` is high at a rising edge, the held word and every slice become zero, and after that edge `ack_o` is low and `dat_o` is zero.
- R2: A read request is `cyc_i`, `stb_i` and `adr_i == REG_ADDR` all high with `we_i` low, at an edge where `ack_o` is low. After that edge, `ack_o` is high for one cycle and `dat_o` equals the value of `usr_rd_i` at that edge.
- R3: A write request is the same condition with `we_i` high. At that edge the held word takes `dat_i`, and `ack_o` is high for the next cycle.
- R4: The held word changes only on a write request. Reads, strobes with `stb_i` or `cyc_i` low, and accesses to other addresses leave every slice unchanged.
- R5: Slice k (lane k of `slice_o`) carries held-word bits [k*SLICE_W +: SLICE_W]. Lane 0 holds the least significant bits. With the defaults, lane 1 is bits 7..4 and lane 0 is bits 3..0.
- R6: `ack_o` is never high in two consecutive cycles, and it is high only after an edge at which a request was present. A strobe held high continuously is therefore acknowledged on alternate cycles.
- R7: When `adr_i` does not match `REG_ADDR`, no acknowledge follows and `dat_o` stays zero.
- R8: `dat_o` is zero in every cycle except the acknowledge cycle of a read, including the acknowledge cycle of a write.
- R9: Read data is the live user input, not the held word. A read after a write returns `usr_rd_i` even when it differs from the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Strobe for this slave |
| we_i | input | 1 | High for write, low for read |
| adr_i | input | ADDR_W | Bus address |
| dat_i | input | DATA_W | Write data from host |
| dat_o | output | DATA_W | Read data to host, zero outside a read acknowledge |
| ack_o | output | 1 | Single-cycle acknowledge |
| usr_rd_i | input | DATA_W | Live value from user logic returned on reads |
| slice_o | output | NUM_SLICES x SLICE_W | Held word split into slices, lane 0 least significant |

## Verification
Directed patterns come first. A write followed by a read with a different live input tells the held word apart from the read path. A write to a neighbouring address and a strobe with `stb_i` low tell real requests apart from near misses. A strobe held high over several cycles separates a correct single-pulse acknowledge from one that repeats. A long stretch of random bus activity, with reset pulses in the middle, is then compared every clock against a behavioural model of the held word, the acknowledge and the read data.

// File: rtl/wbsr_pkg.sv
package wbsr_pkg;

   typedef enum logic {
      ACC_READ  = 1'b0,
      ACC_WRITE = 1'b1
   } acc_kind_e;

   function automatic int unsigned slice_count(input int unsigned word_w,
                                               input int unsigned lane_w);
      return word_w / lane_w;
   endfunction

endpackage

// File: rtl/wbsr_decode.sv
module wbsr_decode
   import wbsr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned REG_ADDR = 5
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              cyc_i,
   input  logic              stb_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] adr_i,
   output logic              ack_o,
   output acc_kind_e         kind_o,
   output logic              wr_fire_o,
   output logic              rd_fire_o
);

   localparam logic [ADDR_W-1:0] MATCH = REG_ADDR[ADDR_W-1:0];

   if (REG_ADDR >= (64'd1 << ADDR_W)) begin : g_bad_addr
      $error("wbsr_decode: REG_ADDR does not fit in ADDR_W bits");
   end

   logic      req;
   logic      fire;
   logic      ack_q;
   acc_kind_e kind_q;

   assign req       = cyc_i & stb_i & (adr_i == MATCH);
   assign fire      = req & ~ack_q;
   assign wr_fire_o = fire & we_i;
   assign rd_fire_o = fire & ~we_i;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         ack_q  <= 1'b0;
         kind_q <= ACC_READ;
      end else begin
         ack_q  <= fire;
         if (fire) kind_q <= we_i ? ACC_WRITE : ACC_READ;
      end
   end

   assign ack_o  = ack_q;
   assign kind_o = kind_q;

   // R6: acknowledge lasts exactly one cycle
   a_r6_single_ack: assert property (@(posedge clk_i) disable iff (rst_i)
      ack_q |=> !ack_q);

   // R6: acknowledge only follows a present request
   a_r6_ack_after_req: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(ack_q) |-> $past(cyc_i && stb_i && (adr_i == MATCH)));

endmodule

// File: rtl/wbsr_hold.sv
module wbsr_hold #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              load_i,
   input  logic [DATA_W-1:0] dat_i,
   output logic [DATA_W-1:0] word_o
);

   logic [DATA_W-1:0] word_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)       word_q <= '0;
      else if (load_i) word_q <= dat_i;
   end

   assign word_o = word_q;

   // R4: held word is stable unless loaded
   a_r4_hold_stable: assert property (@(posedge clk_i) disable iff (rst_i)
      !load_i |=> $stable(word_q));

endmodule

// File: rtl/wbsr_rdcap.sv
module wbsr_rdcap
   import wbsr_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              sample_i,
   input  logic              ack_i,
   input  acc_kind_e         kind_i,
   input  logic [DATA_W-1:0] live_i,
   output logic [DATA_W-1:0] dat_o
);

   logic [DATA_W-1:0] cap_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)         cap_q <= '0;
      else if (sample_i) cap_q <= live_i;
   end

   assign dat_o = (ack_i && kind_i == ACC_READ) ? cap_q : '0;

endmodule

// File: rtl/wbsr_slicer.sv
module wbsr_slicer #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned SLICE_W    = 4,
   parameter int unsigned NUM_SLICES = DATA_W / SLICE_W
) (
   input  logic [DATA_W-1:0]                   word_i,
   output logic [NUM_SLICES-1:0][SLICE_W-1:0]  lane_o
);

   for (genvar k = 0; k < NUM_SLICES; k++) begin : g_lane
      assign lane_o[k] = word_i[k*SLICE_W +: SLICE_W];
   end

endmodule

// File: rtl/wbsr_port.sv
module wbsr_port
   import wbsr_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned SLICE_W    = 4,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned REG_ADDR   = 5,
   localparam int unsigned NUM_SLICES = slice_count(DATA_W, SLICE_W)
) (
   input  logic                               clk_i,
   input  logic                               rst_i,
   input  logic                               cyc_i,
   input  logic                               stb_i,
   input  logic                               we_i,
   input  logic [ADDR_W-1:0]                  adr_i,
   input  logic [DATA_W-1:0]                  dat_i,
   output logic [DATA_W-1:0]                  dat_o,
   output logic                               ack_o,
   input  logic [DATA_W-1:0]                  usr_rd_i,
   output logic [NUM_SLICES-1:0][SLICE_W-1:0] slice_o
);

   if (SLICE_W == 0 || SLICE_W > DATA_W || (DATA_W % SLICE_W) != 0) begin : g_bad_slice
      $error("wbsr_port: SLICE_W must be nonzero and divide DATA_W");
   end

   logic              ack;
   acc_kind_e         kind;
   logic              wr_fire;
   logic              rd_fire;
   logic [DATA_W-1:0] word;

   wbsr_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_decode (
      .clk_i(clk_i), .rst_i(rst_i), .cyc_i(cyc_i), .stb_i(stb_i),
      .we_i(we_i), .adr_i(adr_i), .ack_o(ack), .kind_o(kind),
      .wr_fire_o(wr_fire), .rd_fire_o(rd_fire)
   );

   wbsr_hold #(.DATA_W(DATA_W)) u_hold (
      .clk_i(clk_i), .rst_i(rst_i), .load_i(wr_fire),
      .dat_i(dat_i), .word_o(word)
   );

   wbsr_rdcap #(.DATA_W(DATA_W)) u_rdcap (
      .clk_i(clk_i), .rst_i(rst_i), .sample_i(rd_fire), .ack_i(ack),
      .kind_i(kind), .live_i(usr_rd_i), .dat_o(dat_o)
   );

   wbsr_slicer #(.DATA_W(DATA_W), .SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)) u_slicer (
      .word_i(word), .lane_o(slice_o)
   );

   assign ack_o = ack;

   // R3: a write acknowledge shows the written data on the slices
   a_r3_write_lands: assert property (@(posedge clk_i) disable iff (rst_i)
      (ack_o && $past(we_i)) |-> (slice_o == $past(dat_i)));

   // R2, R9: a read acknowledge returns the live input seen at the request
   a_r2_read_value: assert property (@(posedge clk_i) disable iff (rst_i)
      (ack_o && !$past(we_i)) |-> (dat_o == $past(usr_rd_i)));

   // R8: no read data during a write acknowledge or an idle cycle
   a_r8_dat_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
      (!ack_o || $past(we_i)) |-> (dat_o == '0));

   // R7: a mismatched address never produces an acknowledge
   a_r7_miss_no_ack: assert property (@(posedge clk_i) disable iff (rst_i)
      (cyc_i && stb_i && adr_i != REG_ADDR[ADDR_W-1:0]) |=> !ack_o);

endmodule

// File: tb/wbsr_port_test.sv
module wbsr_port_test;

   localparam int DW = 8;
   localparam int SW = 4;
   localparam int AW = 4;
   localparam int RA = 5;
   localparam int NS = DW / SW;

   logic                    clk = 1'b0;
   logic                    rst, cyc, stb, we;
   logic [AW-1:0]           adr;
   logic [DW-1:0]           dat_i, usr_rd, dat_o;
   logic                    ack;
   logic [NS-1:0][SW-1:0]   slices;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural reference
   logic [DW-1:0] m_word = '0;
   logic [DW-1:0] m_dat  = '0;
   logic          m_ack  = 1'b0;

   always #5 clk = ~clk;

   wbsr_port #(.DATA_W(DW), .SLICE_W(SW), .ADDR_W(AW), .REG_ADDR(RA)) uut (
      .clk_i(clk), .rst_i(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we),
      .adr_i(adr), .dat_i(dat_i), .dat_o(dat_o), .ack_o(ack),
      .usr_rd_i(usr_rd), .slice_o(slices)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one clock: update model at the edge, compare at the falling edge
   task automatic tick();
      logic fire;
      @(posedge clk);
      fire = cyc && stb && (adr == RA[AW-1:0]) && !m_ack;
      if (rst) begin
         m_word = '0; m_ack = 1'b0; m_dat = '0;
      end else begin
         m_ack = fire;
         m_dat = (fire && !we) ? usr_rd : '0;
         if (fire && we) m_word = dat_i;
      end
      @(negedge clk);
      check(ack === m_ack, "R6 ack", 32'(ack), 32'(m_ack));
      check(dat_o === m_dat, "R2/R8 dat_o", 32'(dat_o), 32'(m_dat));
      check(slices === m_word, "R3/R4 slices", 32'(slices), 32'(m_word));
   endtask

   task automatic drive(input logic c, input logic s, input logic w,
                        input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [DW-1:0] r);
      cyc = c; stb = s; we = w; adr = a; dat_i = d; usr_rd = r;
   endtask

   task automatic idle();
      drive(0, 0, 0, '0, '0, usr_rd);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst = 1'b1;
      drive(0, 0, 0, '0, '0, 8'h00);
      @(negedge clk);
      tick(); tick();
      // R1: reset state
      check(slices === '0 && ack === 1'b0 && dat_o === '0, "R1 reset",
            32'(slices), 0);
      rst = 1'b0;
      tick();

      // R3, R5: write 0x3C
      drive(1, 1, 1, AW'(RA), 8'h3C, 8'h00);
      tick();
      check(ack === 1'b1, "R3 write ack", 32'(ack), 1);
      check(slices[0] === 4'hC, "R5 lane0", 32'(slices[0]), 32'hC);
      check(slices[1] === 4'h3, "R5 lane1", 32'(slices[1]), 32'h3);
      check(dat_o === '0, "R8 dat on write ack", 32'(dat_o), 0);
      idle(); tick();

      // R2, R9: read returns live input, not held word
      drive(1, 1, 0, AW'(RA), 8'h00, 8'h81);
      tick();
      check(ack === 1'b1 && dat_o === 8'h81, "R9 live read", 32'(dat_o), 32'h81);
      usr_rd = 8'h55;
      idle(); tick();
      check(dat_o === '0, "R8 dat idle", 32'(dat_o), 0);
      check(slices === 8'h3C, "R4 read kept word", 32'(slices), 32'h3C);

      // R7: other address
      drive(1, 1, 1, AW'(RA + 1), 8'hFF, 8'hAA);
      tick(); tick(); tick();
      check(ack === 1'b0 && dat_o === '0, "R7 miss", 32'(ack), 0);
      check(slices === 8'h3C, "R4 miss kept word", 32'(slices), 32'h3C);

      // R4: strobe low or cycle low
      drive(1, 0, 1, AW'(RA), 8'h99, 8'h00);
      tick(); tick();
      drive(0, 1, 1, AW'(RA), 8'h99, 8'h00);
      tick(); tick();
      check(slices === 8'h3C && ack === 1'b0, "R4 no strobe", 32'(slices), 32'h3C);

      // R6: strobe held high, ack alternates
      drive(1, 1, 0, AW'(RA), 8'h00, 8'h12);
      tick();
      check(ack === 1'b1, "R6 first ack", 32'(ack), 1);
      tick();
      check(ack === 1'b0, "R6 gap", 32'(ack), 0);
      tick();
      check(ack === 1'b1 && dat_o === 8'h12, "R6 second ack", 32'(ack), 1);
      idle(); tick();

      // R1: reset mid-run clears held word
      rst = 1'b1; tick(); rst = 1'b0;
      check(slices === '0, "R1 mid reset", 32'(slices), 0);

      // random traffic against the model
      for (int i = 0; i < 3000; i++) begin
         rst = ($urandom_range(0, 199) == 0);
         drive(1'($urandom), 1'($urandom), 1'($urandom),
               ($urandom_range(0, 2) != 0) ? AW'(RA) : AW'($urandom),
               DW'($urandom), DW'($urandom));
         tick();
      end
      rst = 1'b0; idle(); tick();

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule